// File: doc/BRIEF.md
# Eight-Slot TDM Audio Serial Port

This block moves audio between a host and a multichannel converter over a time-division-multiplexed serial link. Each frame carries eight 32-bit timeslots, so one frame lasts 256 bit clocks. The converter supplies the bit clock and the frame sync. Each frame matches one audio sample period: at 48 kHz the bit clock is 12.288 MHz, and at 96 kHz it doubles. Converter samples occupy 24 bits inside each 32-bit slot word. The port passes all 32 bits through without changing them.

The port runs on its own system clock. It brings the bit clock, frame sync and receive line in through synchronizer chains, then finds the bit-clock edges by comparing stages. Received slots are deserialized into a bank of eight words and reported with a frame-done strobe. Transmit frames come in on a valid/ready port into a one-frame holding register. Each frame start moves the held frame to the serializer.

Transmit back-pressure works as follows. `tx_ready_o` is high while the holding register is empty. A frame is taken on a clock where `tx_valid_i` and `tx_ready_o` are both high. The producer keeps `tx_frame_i` steady until that happens. If the holding register is empty when a frame starts, that frame transmits zeros. The receive side has no back-pressure, because the link cannot stall. Each received word holds its value until the port writes that slot again.

Top module: `tdm_audio_port`

## Requirements
- R1: A frame starts when a falling bit-clock edge sees frame sync high after the previous falling edge saw it low. Each frame is 8 slots of 32 bits, 256 bit clocks in all.
- R2: Receive data is taken MSB first on falling edges. Bit 31 of slot 0 is taken on the first falling edge after the one that detected the frame. Slot s occupies `rx_frame_o[32*s+31:32*s]`.
- R3: `txd_o` changes only after a rising bit-clock edge, MSB first. During the high phase before the falling edge that samples bit b of slot s, it carries bit 31-b of slot s. Slot s of the transmit frame is `tx_frame_i[32*s+31:32*s]`. When no frame is running, `txd_o` is 0.
- R4: Bit s of `slot_en_i` enables slot s. A received slot whose enable bit is 0 is not written and keeps its earlier value.
- R5: A transmit slot whose enable bit is 0 drives 0 for all of its 32 bits.
- R6: `frame_done_o` is high for exactly one system clock after the last bit of slot 7 is received. All enabled received words of that frame are visible on `rx_frame_o` in that same cycle.
- R7: A frame start in the middle of a frame resets the count to slot 0, bit 31. The partial frame produces no `frame_done_o`.
- R8: `tx_ready_o` is high exactly when the holding register is empty, and it goes low on the clock after a frame is accepted. An accepted frame is transmitted in the next frame that starts. A frame that starts while the holding register is empty transmits all zeros.
- R9: After reset, `txd_o` and `frame_done_o` are 0, `rx_frame_o` is all zeros and `tx_ready_o` is 1.
- R10: Frame sync held high over several bit clocks starts only one frame. Frame sync rising again in the sample that carries a frame's last bit starts the next frame with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above twice the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the converter |
| fsync_i | input | 1 | Frame sync, launched on the rising bit-clock edge |
| rxd_i | input | 1 | Serial data from the converter |
| txd_o | output | 1 | Serial data to the converter |
| slot_en_i | input | 8 | Per-slot enable mask, bit s for slot s |
| tx_valid_i | input | 1 | Transmit frame offered |
| tx_ready_o | output | 1 | Holding register empty |
| tx_frame_i | input | 256 | Eight transmit slot words, slot s at bits 32*s+31..32*s |
| rx_frame_o | output | 256 | Eight received slot words, same layout |
| frame_done_o | output | 1 | One-cycle strobe at the end of each full frame |

## Verification
The bench targets four corner cases:
- Back-to-back frames whose sync edge coincides with the last data bit. A design that did not end the old frame and start the new one in the same sample would lose slot 7 or shift every later slot by one bit.
- Masks of none, all and mixed slots. A wrong design would overwrite masked receive words or leak masked transmit data.
- A frame sync arriving partway through a frame. A design that did not resynchronize would misalign the next frame or emit a strobe for the fragment.
- A frame sync held high for ten bit clocks. A level-sensitive design would restart the frame repeatedly.

An empty holding register at frame start must give an all-zero transmit frame. A design that reused stale data would fail that check.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // Bit-clock events and aligned line samples, all in the system clock domain
  typedef struct packed {
    logic rise;
    logic fall;
    logic fs;
    logic dat;
  } tdm_evt_t;
endpackage

// File: rtl/tdm_edge_sync.sv
module tdm_edge_sync
  import tdm_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bclk_i,
  input  logic     fsync_i,
  input  logic     rxd_i,
  output tdm_evt_t evt_o
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] b_sy, f_sy, d_sy;
  logic              b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_sy <= '0;
      f_sy <= '0;
      d_sy <= '0;
      b_q  <= 1'b0;
    end else begin
      b_sy <= {b_sy[STAGES-2:0], bclk_i};
      f_sy <= {f_sy[STAGES-2:0], fsync_i};
      d_sy <= {d_sy[STAGES-2:0], rxd_i};
      b_q  <= b_sy[TOP];
    end
  end

  assign evt_o.rise = b_sy[TOP] & ~b_q;
  assign evt_o.fall = ~b_sy[TOP] & b_q;
  assign evt_o.fs   = f_sy[TOP];
  assign evt_o.dat  = d_sy[TOP];
endmodule

// File: rtl/tdm_frame_ctrl.sv
module tdm_frame_ctrl #(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 fall_i,
  input  logic                                 fs_i,
  output logic                                 active_o,
  output logic [$clog2(SLOTS*SLOT_BITS)-1:0]   bitcnt_o,
  output logic                                 frame_start_o,
  output logic                                 samp_o,
  output logic                                 frame_last_o
);
  localparam int CW = $clog2(SLOTS*SLOT_BITS);
  localparam logic [CW-1:0] LAST = CW'(SLOTS*SLOT_BITS - 1);

  logic fs_prev;

  assign frame_start_o = fall_i & fs_i & ~fs_prev;
  assign samp_o        = fall_i & active_o;
  assign frame_last_o  = samp_o & (bitcnt_o == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_prev  <= 1'b0;
      active_o <= 1'b0;
      bitcnt_o <= '0;
    end else if (fall_i) begin
      fs_prev <= fs_i;
      if (frame_start_o) begin
        active_o <= 1'b1;
        bitcnt_o <= '0;
      end else if (active_o) begin
        if (bitcnt_o == LAST) begin
          active_o <= 1'b0;
          bitcnt_o <= '0;
        end else begin
          bitcnt_o <= bitcnt_o + 1'b1;
        end
      end
    end
  end

  AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> (active_o && bitcnt_o == '0)); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_o && !frame_start_o && bitcnt_o != LAST) |=> (bitcnt_o == $past(bitcnt_o) + 1'b1)); // R1
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                samp_i,
  input  logic                                dat_i,
  input  logic [$clog2(SLOTS*SLOT_BITS)-1:0]  bitcnt_i,
  input  logic [SLOTS-1:0]                    slot_en_i,
  input  logic                                frame_last_i,
  output logic [SLOTS*SLOT_BITS-1:0]          rx_frame_o,
  output logic                                frame_done_o
);
  localparam int CW = $clog2(SLOTS*SLOT_BITS);
  localparam int BW = $clog2(SLOT_BITS);

  logic [SLOT_BITS-1:0] words [SLOTS];
  logic [SLOT_BITS-2:0] shreg;
  logic [CW-BW-1:0]     slot;
  logic                 word_end;

  assign slot     = bitcnt_i[CW-1:BW];
  assign word_end = samp_i & (&bitcnt_i[BW-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg        <= '0;
      frame_done_o <= 1'b0;
      for (int s = 0; s < SLOTS; s++) words[s] <= '0;
    end else begin
      frame_done_o <= frame_last_i;
      if (samp_i) shreg <= {shreg[SLOT_BITS-3:0], dat_i};
      if (word_end && slot_en_i[slot]) words[slot] <= {shreg, dat_i};
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_out
    assign rx_frame_o[g*SLOT_BITS +: SLOT_BITS] = words[g];
    AST_RX_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_en_i[g] |=> $stable(words[g])); // R4
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !frame_done_o); // R6
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser #(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                rise_i,
  input  logic                                active_i,
  input  logic [$clog2(SLOTS*SLOT_BITS)-1:0]  bitcnt_i,
  input  logic [SLOTS-1:0]                    slot_en_i,
  input  logic                                frame_start_i,
  input  logic                                tx_valid_i,
  input  logic [SLOTS*SLOT_BITS-1:0]          tx_frame_i,
  output logic                                tx_ready_o,
  output logic                                txd_o
);
  localparam int CW = $clog2(SLOTS*SLOT_BITS);
  localparam int BW = $clog2(SLOT_BITS);

  logic [SLOTS*SLOT_BITS-1:0] hold;
  logic [SLOT_BITS-1:0]       cur [SLOTS];
  logic                       full;
  logic [CW-BW-1:0]           slot;
  logic [BW-1:0]              msb_idx;

  assign slot       = bitcnt_i[CW-1:BW];
  assign msb_idx    = BW'(SLOT_BITS - 1) - bitcnt_i[BW-1:0];
  assign tx_ready_o = ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      full  <= 1'b0;
      txd_o <= 1'b0;
      for (int s = 0; s < SLOTS; s++) cur[s] <= '0;
    end else begin
      if (tx_valid_i && !full) begin
        hold <= tx_frame_i;
        full <= 1'b1;
      end else if (frame_start_i) begin
        full <= 1'b0;
      end
      if (frame_start_i) begin
        for (int s = 0; s < SLOTS; s++)
          cur[s] <= full ? hold[s*SLOT_BITS +: SLOT_BITS] : '0;
      end
      if (rise_i) txd_o <= active_i & slot_en_i[slot] & cur[slot][msb_idx];
    end
  end

  AST_TX_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_i |=> $stable(txd_o)); // R3
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid_i && tx_ready_o) |=> !tx_ready_o); // R8
  AST_TX_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !slot_en_i[slot]) |=> !txd_o); // R5
endmodule

// File: rtl/tdm_audio_port.sv
module tdm_audio_port
  import tdm_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bclk_i,
  input  logic                       fsync_i,
  input  logic                       rxd_i,
  output logic                       txd_o,
  input  logic [SLOTS-1:0]           slot_en_i,
  input  logic                       tx_valid_i,
  output logic                       tx_ready_o,
  input  logic [SLOTS*SLOT_BITS-1:0] tx_frame_i,
  output logic [SLOTS*SLOT_BITS-1:0] rx_frame_o,
  output logic                       frame_done_o
);
  localparam int CW = $clog2(SLOTS*SLOT_BITS);

  tdm_evt_t        evt;
  logic            active, frame_start, samp, frame_last;
  logic [CW-1:0]   bitcnt;

  tdm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
    .rxd_i(rxd_i), .evt_o(evt)
  );

  tdm_frame_ctrl #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fall_i(evt.fall), .fs_i(evt.fs),
    .active_o(active), .bitcnt_o(bitcnt), .frame_start_o(frame_start),
    .samp_o(samp), .frame_last_o(frame_last)
  );

  tdm_rx_deser #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n), .samp_i(samp), .dat_i(evt.dat),
    .bitcnt_i(bitcnt), .slot_en_i(slot_en_i), .frame_last_i(frame_last),
    .rx_frame_o(rx_frame_o), .frame_done_o(frame_done_o)
  );

  tdm_tx_ser #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n), .rise_i(evt.rise), .active_i(active),
    .bitcnt_i(bitcnt), .slot_en_i(slot_en_i), .frame_start_i(frame_start),
    .tx_valid_i(tx_valid_i), .tx_frame_i(tx_frame_i),
    .tx_ready_o(tx_ready_o), .txd_o(txd_o)
  );
endmodule

// File: tb/tb_tdm_audio_port.sv
module tb_tdm_audio_port;
  localparam int NV = 5;
  // {mask, tx seed, rx seed}
  localparam logic [71:0] VEC [NV] = '{
    {8'hFF, 32'h1234_5678, 32'hCAFE_0001},
    {8'hA5, 32'h8BAD_F00D, 32'h0F0F_3C3C},
    {8'h00, 32'hDEAD_BEEF, 32'h5555_AAAA},
    {8'h81, 32'h7654_3210, 32'hF00D_1234},
    {8'h7E, 32'h0000_0001, 32'h9999_0007}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
  logic txd, tx_ready, frame_done;
  logic [7:0] slot_en = 8'hFF;
  logic tx_valid = 1'b0;
  logic [255:0] tx_frame = '0;
  logic [255:0] rx_frame;

  int checks = 0, failures = 0, done_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tdm_audio_port dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fsync_i(fsync), .rxd_i(rxd),
    .txd_o(txd), .slot_en_i(slot_en), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_frame_i(tx_frame), .rx_frame_o(rx_frame),
    .frame_done_o(frame_done)
  );

  always @(negedge clk) if (rst_n && frame_done) done_cnt++;

  function automatic logic [255:0] gen(input logic [31:0] seed);
    logic [255:0] f;
    for (int s = 0; s < 8; s++)
      f[s*32 +: 32] = (seed * 32'(2*s + 3)) ^ {4'(s), 28'h0};
    return f;
  endfunction

  function automatic logic [255:0] masked(input logic [255:0] f, input logic [7:0] en);
    logic [255:0] m;
    for (int s = 0; s < 8; s++) m[s*32 +: 32] = en[s] ? f[s*32 +: 32] : 32'h0;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_clk(input logic fs, input logic d, output logic t);
    @(negedge clk); bclk = 1'b1; fsync = fs; rxd = d;
    repeat (3) @(negedge clk);
    t = txd;
    @(negedge clk); bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic push(input logic [255:0] d);
    @(negedge clk);
    chk(tx_ready === 1'b1, "R8 ready before accept", 256'(tx_ready), 256'(1));
    tx_valid = 1'b1; tx_frame = d;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready === 1'b0, "R8 ready low after accept", 256'(tx_ready), 256'(0));
  endtask

  task automatic run_frame(input logic [255:0] rxf, input bit lead, input bit fs_last,
                           input int fs_hold, input int nbits, input bit do_push,
                           input logic [255:0] pd, output logic [255:0] cap);
    logic t;
    cap = '0;
    if (lead) bit_clk(1'b1, 1'b0, t);
    for (int n = 0; n < nbits; n++) begin
      bit_clk(logic'((n < fs_hold) || (fs_last && n == 255)), rxf[(n/32)*32 + 31 - (n%32)], t);
      cap[(n/32)*32 + 31 - (n%32)] = t;
      if (do_push && n == 8) push(pd);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [255:0] exp_rx, cap, rxf, exp_tx;
    int d0;
    exp_rx = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R9 reset state
    chk(txd === 1'b0 && frame_done === 1'b0, "R9 txd/done after reset", 256'({txd, frame_done}), 256'(0));
    chk(tx_ready === 1'b1, "R9 ready after reset", 256'(tx_ready), 256'(1));
    chk(rx_frame === '0, "R9 rx words after reset", rx_frame, '0);

    // Vector table: back-to-back frames, sync coinciding with last bit (R10)
    push(gen(VEC[0][63:32]));
    for (int i = 0; i < NV; i++) begin
      slot_en = VEC[i][71:64];
      rxf = gen(VEC[i][31:0]);
      d0 = done_cnt;
      run_frame(rxf, i == 0, i < NV-1, 0, 256, i < NV-1,
                (i < NV-1) ? gen(VEC[(i+1) % NV][63:32]) : '0, cap);
      exp_tx = masked(gen(VEC[i][63:32]), VEC[i][71:64]);
      chk(cap === exp_tx, "R3 R5 tx stream", cap, exp_tx);
      for (int s = 0; s < 8; s++) if (VEC[i][64+s]) exp_rx[s*32 +: 32] = rxf[s*32 +: 32];
      chk(rx_frame === exp_rx, "R2 R4 R10 rx words", rx_frame, exp_rx);
      chk(done_cnt == d0 + 1, "R6 R1 one strobe per frame", 256'(done_cnt - d0), 256'(1));
    end

    // R8 underrun: holding empty at frame start -> zeros
    slot_en = 8'hFF;
    rxf = gen(32'h3141_5926);
    run_frame(rxf, 1, 0, 0, 256, 0, '0, cap);
    chk(cap === '0, "R8 underrun zeros", cap, '0);
    chk(rx_frame === rxf, "R2 full mask rx", rx_frame, rxf);

    // R7 mid-frame resync
    d0 = done_cnt;
    run_frame(gen(32'hAAAA_5555), 1, 0, 0, 100, 0, '0, cap);
    rxf = gen(32'h2718_2818);
    run_frame(rxf, 1, 0, 0, 256, 0, '0, cap);
    chk(done_cnt == d0 + 1, "R7 no strobe for partial frame", 256'(done_cnt - d0), 256'(1));
    chk(rx_frame === rxf, "R7 realigned rx words", rx_frame, rxf);

    // R10 sync held high for ten bit clocks
    d0 = done_cnt;
    rxf = gen(32'h0BAD_CAFE);
    run_frame(rxf, 1, 0, 10, 256, 0, '0, cap);
    chk(done_cnt == d0 + 1, "R10 held sync one frame", 256'(done_cnt - d0), 256'(1));
    chk(rx_frame === rxf, "R10 held sync rx words", rx_frame, rxf);
    chk(txd === 1'b0, "R3 idle line low", 256'(txd), 256'(0));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule